// File: doc/BRIEF.md
# Instrument Bus Program Decoder

This block sits behind a byte-wide instrument bus and holds a measuring instrument's remotely programmed state. A controller drives a command-phase flag (active low) and presents one byte per `byteValid` pulse. In the command phase every byte is a bus command. The block compares addressing commands against a 5-bit device address and tracks whether the device is currently addressed to listen and whether it is addressed to talk. It also acts on the device-clear commands.

Outside the command phase, bytes reach the block only while the device is addressed to listen. The block parses them as a letter-prefixed ASCII program language. A prefix letter routes the character after it into a function register, a time-base register, a bit-per-pair mode register or a signed trigger level for one of two channels. A few letters act at once: they change the blanking state or emit one-cycle reset and trigger strobes.

Each byte is taken on the rising clock edge on which `byteValid` is high. Every resulting register change and every strobe is visible from that edge until the next one. Only the low seven bits of any byte are decoded.

Top module: `prog_listener`

## Requirements
- R1: After reset both addressed flags are 0. The function code is 4, the time base is 0, the mode register is 0x00, blanking is off, both levels are 0 and both strobes are low.
- R2: A command byte whose low seven bits are 0x20 plus `devAddr` sets the listen flag. The command 0x3F clears it. A listen address for another device leaves the flag unchanged.
- R3: A command byte in 0x40 to 0x5E sets the talk flag when its low five bits equal `devAddr` and clears it otherwise. The command 0x5F clears the talk flag. Bit 7 of a command is ignored.
- R4: Program bytes change nothing unless the command phase is inactive (`cmdModeN` high) and the listen flag is set.
- R5: After 'F', a character from 0x30 to 0x3F loads its low nibble into the function code. After 'G', a character from '0' to '7' loads the time base. Any other character after either prefix is discarded, the register keeps its value, and the parser returns to idle.
- R6: After 'S', each character c from 0x30 to 0x3F writes mode bit (c-0x30)>>1 with the value (c-0x30)&1, and the parser stays in the mode group. Any other character ends the group and is decoded as a fresh character.
- R7: 'Q' turns blanking on and 'U' turns it off. 'R' raises `resetPulse` for exactly one cycle. 'T' raises `resetPulse` and `trigPulse` together for one cycle. Each strobe is high in the cycle after the byte's edge.
- R8: The program letter 'P', the command 0x14 (for any device) and the command 0x04 (only while the listen flag is set) each restore the R1 configuration values and return the parser to idle. The addressed flags are not changed.
- R9: The sequence 'A' or 'B', then '+' or '-', then three decimal digits, then '*' loads that channel's level as a two's-complement number of hundredths of a volt. Channel A is 'A' and channel B is 'B'.
- R10: A trigger-level sequence that breaks the R9 form, or whose magnitude is above 250, is discarded. The previous level is kept and the parser returns to idle, so the character that breaks the form is itself consumed.
- R11: While `busClear` is high, both addressed flags clear and any partial parse is dropped. All configuration registers keep their values, and the byte on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busClear | input | 1 | Interface clear, synchronous, active high |
| cmdModeN | input | 1 | Low while bytes are bus commands |
| byteValid | input | 1 | Byte strobe, one edge per byte |
| byteIn | input | 8 | Bus data byte |
| devAddr | input | 5 | Device address switch setting |
| listenActive | output | 1 | Device is addressed to listen |
| talkActive | output | 1 | Device is addressed to talk |
| funcCode | output | 4 | Selected measurement function |
| timeBase | output | 3 | Selected time-base code |
| modeBits | output | 8 | Mode register, one bit per code pair |
| displayBlank | output | 1 | Display blanking state |
| levelA | output | LVL_W | Channel A trigger level in hundredths, signed |
| levelB | output | LVL_W | Channel B trigger level in hundredths, signed |
| resetPulse | output | 1 | One-cycle reset strobe |
| trigPulse | output | 1 | One-cycle trigger strobe |

## Verification
The bench goes after several corner cases:
- Talk addresses for other devices. A design that only ever set the talk flag would leave two talkers on the bus.
- A mode group that ends on a letter. A decoder that swallowed the terminating 'Q' would miss the blanking request.
- Trigger levels of exactly 250 and 251, a sequence cut short by '*' after two digits, and a negative zero. An off-by-one range check or a missing digit count would corrupt the stored level.
- A selected device clear arriving while the device is not listening, and an interface clear in the middle of a level sequence. A wrong design would reset the configuration or finish the stale sequence after the device is addressed again.

// File: rtl/prog_listener_pkg.sv
package prog_listener_pkg;
  localparam int NUM_CH = 2;

  localparam logic [6:0] CH_F = 7'h46, CH_G = 7'h47, CH_S = 7'h53;
  localparam logic [6:0] CH_A = 7'h41, CH_B = 7'h42, CH_P = 7'h50;
  localparam logic [6:0] CH_Q = 7'h51, CH_U = 7'h55, CH_R = 7'h52;
  localparam logic [6:0] CH_T = 7'h54, CH_PLUS = 7'h2B, CH_MINUS = 7'h2D;
  localparam logic [6:0] CH_STAR = 7'h2A;
  localparam logic [6:0] CMD_UNLISTEN = 7'h3F, CMD_UNTALK = 7'h5F;
  localparam logic [6:0] CMD_DEVCLR = 7'h14, CMD_SELCLR = 7'h04;

  typedef enum logic [2:0] {
    PS_IDLE, PS_FUNC, PS_TB, PS_MODE, PS_SIGN, PS_DIG, PS_STAR
  } parseSt_t;

  typedef struct packed {
    logic       ldFunc;
    logic       ldTb;
    logic       ldModeBit;
    logic       accClr;
    logic       accPush;
    logic       ldLevel;
    logic       setDefaults;
    logic       setBlank;
    logic       clrBlank;
    logic       chSel;
    logic       negSel;
    logic [3:0] code;
  } progStrobe_t;
endpackage

// File: rtl/prog_listener_ctrl.sv
module prog_listener_ctrl
  import prog_listener_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busClear,
  input  logic        cmdModeN,
  input  logic        byteValid,
  input  logic [7:0]  byteIn,
  input  logic [4:0]  devAddr,
  output logic        listenActive,
  output logic        talkActive,
  output logic        resetPulse,
  output logic        trigPulse,
  output progStrobe_t stb
);
  parseSt_t st, stNext;
  logic [1:0] digCnt, digCntNext;
  logic chReg, chNext, negReg, negNext;
  logic rstReq, trgReq, redispatch;
  logic [6:0] ch7;
  logic cmdByte, progByte, isCode, isDigit;

  assign ch7      = byteIn[6:0];
  assign cmdByte  = byteValid && !cmdModeN && !busClear;
  assign progByte = byteValid && cmdModeN && listenActive && !busClear;
  assign isCode   = (ch7[6:4] == 3'b011);
  assign isDigit  = isCode && (ch7[3:0] <= 4'd9);

  always_comb begin
    stb = '0;
    stb.code = ch7[3:0];
    stb.chSel = chReg;
    stb.negSel = negReg;
    stNext = st;
    digCntNext = digCnt;
    chNext = chReg;
    negNext = negReg;
    rstReq = 1'b0;
    trgReq = 1'b0;
    redispatch = 1'b0;
    if (cmdByte)
      stb.setDefaults = (ch7 == CMD_DEVCLR) || (ch7 == CMD_SELCLR && listenActive);
    if (progByte) begin
      unique case (st)
        PS_IDLE: redispatch = 1'b1;
        PS_FUNC: begin
          stb.ldFunc = isCode;
          stNext = PS_IDLE;
        end
        PS_TB: begin
          stb.ldTb = isCode && !ch7[3];
          stNext = PS_IDLE;
        end
        PS_MODE: begin
          if (isCode) stb.ldModeBit = 1'b1;
          else redispatch = 1'b1;
        end
        PS_SIGN: begin
          if (ch7 == CH_PLUS || ch7 == CH_MINUS) begin
            stb.accClr = 1'b1;
            negNext = (ch7 == CH_MINUS);
            digCntNext = 2'd0;
            stNext = PS_DIG;
          end else stNext = PS_IDLE;
        end
        PS_DIG: begin
          if (isDigit) begin
            stb.accPush = 1'b1;
            digCntNext = digCnt + 2'd1;
            stNext = (digCnt == 2'd2) ? PS_STAR : PS_DIG;
          end else stNext = PS_IDLE;
        end
        PS_STAR: begin
          stb.ldLevel = (ch7 == CH_STAR);
          stNext = PS_IDLE;
        end
        default: stNext = PS_IDLE;
      endcase
      if (redispatch) begin
        stNext = PS_IDLE;
        unique case (ch7)
          CH_F: stNext = PS_FUNC;
          CH_G: stNext = PS_TB;
          CH_S: stNext = PS_MODE;
          CH_A: begin chNext = 1'b0; stNext = PS_SIGN; end
          CH_B: begin chNext = 1'b1; stNext = PS_SIGN; end
          CH_P: stb.setDefaults = 1'b1;
          CH_Q: stb.setBlank = 1'b1;
          CH_U: stb.clrBlank = 1'b1;
          CH_R: rstReq = 1'b1;
          CH_T: begin rstReq = 1'b1; trgReq = 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= PS_IDLE;
      digCnt <= '0;
      chReg <= 1'b0;
      negReg <= 1'b0;
      listenActive <= 1'b0;
      talkActive <= 1'b0;
      resetPulse <= 1'b0;
      trigPulse <= 1'b0;
    end else begin
      resetPulse <= rstReq;
      trigPulse <= trgReq;
      if (busClear) begin
        st <= PS_IDLE;
        listenActive <= 1'b0;
        talkActive <= 1'b0;
      end else begin
        if (stb.setDefaults) st <= PS_IDLE;
        else if (progByte) st <= stNext;
        digCnt <= digCntNext;
        chReg <= chNext;
        negReg <= negNext;
        if (cmdByte) begin
          if (ch7 == CMD_UNLISTEN) listenActive <= 1'b0;
          else if (ch7[6:5] == 2'b01 && ch7[4:0] == devAddr) listenActive <= 1'b1;
          if (ch7 == CMD_UNTALK) talkActive <= 1'b0;
          else if (ch7[6:5] == 2'b10) talkActive <= (ch7[4:0] == devAddr);
        end
      end
    end
  end
endmodule

// File: rtl/prog_listener_dp.sv
module prog_listener_dp
  import prog_listener_pkg::*;
#(
  parameter int LVL_W    = 10,
  parameter int LVL_MAX  = 250,
  parameter int DEF_FUNC = 4,
  parameter int DEF_TB   = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  progStrobe_t                   stb,
  output logic [3:0]                    funcCode,
  output logic [2:0]                    timeBase,
  output logic [7:0]                    modeBits,
  output logic                          displayBlank,
  output logic [NUM_CH-1:0][LVL_W-1:0]  levels
);
  localparam int ACC_W = $clog2(1000);
  localparam int MUL_W = ACC_W + 4;

  logic [ACC_W-1:0] acc;
  logic [MUL_W-1:0] accMul;
  logic             inRange;
  logic signed [LVL_W-1:0] magS, levelVal;

  assign accMul   = {4'b0, acc} * MUL_W'(10) + MUL_W'(stb.code);
  assign inRange  = (acc <= ACC_W'(LVL_MAX));
  assign magS     = LVL_W'(acc);
  assign levelVal = stb.negSel ? -magS : magS;

  always_ff @(posedge clk) begin
    if (!rstN || stb.setDefaults) begin
      funcCode <= 4'(DEF_FUNC);
      timeBase <= 3'(DEF_TB);
      modeBits <= '0;
      displayBlank <= 1'b0;
      acc <= '0;
    end else begin
      if (stb.ldFunc) funcCode <= stb.code;
      if (stb.ldTb) timeBase <= stb.code[2:0];
      if (stb.ldModeBit) modeBits[stb.code[3:1]] <= stb.code[0];
      if (stb.setBlank) displayBlank <= 1'b1;
      else if (stb.clrBlank) displayBlank <= 1'b0;
      if (stb.accClr) acc <= '0;
      else if (stb.accPush) acc <= accMul[ACC_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_level
    always_ff @(posedge clk) begin
      if (!rstN || stb.setDefaults) levels[i] <= '0;
      else if (stb.ldLevel && inRange && (int'(stb.chSel) == i)) levels[i] <= levelVal;
    end
  end
endmodule

// File: rtl/prog_listener.sv
module prog_listener
  import prog_listener_pkg::*;
#(
  parameter int LVL_W    = 10,
  parameter int LVL_MAX  = 250,
  parameter int DEF_FUNC = 4,
  parameter int DEF_TB   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busClear,
  input  logic             cmdModeN,
  input  logic             byteValid,
  input  logic [7:0]       byteIn,
  input  logic [4:0]       devAddr,
  output logic             listenActive,
  output logic             talkActive,
  output logic [3:0]       funcCode,
  output logic [2:0]       timeBase,
  output logic [7:0]       modeBits,
  output logic             displayBlank,
  output logic [LVL_W-1:0] levelA,
  output logic [LVL_W-1:0] levelB,
  output logic             resetPulse,
  output logic             trigPulse
);
  progStrobe_t stb;
  logic [NUM_CH-1:0][LVL_W-1:0] levels;

  prog_listener_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busClear(busClear), .cmdModeN(cmdModeN),
    .byteValid(byteValid), .byteIn(byteIn), .devAddr(devAddr),
    .listenActive(listenActive), .talkActive(talkActive),
    .resetPulse(resetPulse), .trigPulse(trigPulse), .stb(stb)
  );

  prog_listener_dp #(
    .LVL_W(LVL_W), .LVL_MAX(LVL_MAX), .DEF_FUNC(DEF_FUNC), .DEF_TB(DEF_TB)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .funcCode(funcCode),
    .timeBase(timeBase), .modeBits(modeBits), .displayBlank(displayBlank),
    .levels(levels)
  );

  assign levelA = levels[0];
  assign levelB = levels[1];
endmodule

// File: rtl/prog_listener_chk.sv
module prog_listener_chk #(
  parameter int LVL_W   = 10,
  parameter int LVL_MAX = 250
) (
  input logic             clk,
  input logic             rstN,
  input logic             busClear,
  input logic             cmdModeN,
  input logic             byteValid,
  input logic [7:0]       byteIn,
  input logic [4:0]       devAddr,
  input logic             listenActive,
  input logic             talkActive,
  input logic [3:0]       funcCode,
  input logic [2:0]       timeBase,
  input logic [7:0]       modeBits,
  input logic             displayBlank,
  input logic [LVL_W-1:0] levelA,
  input logic [LVL_W-1:0] levelB,
  input logic             resetPulse,
  input logic             trigPulse
);
  p_trig_with_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> resetPulse);

  p_pulse_needs_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> $past(byteValid && cmdModeN));

  p_clear_drops_addr_r11: assert property (@(posedge clk) disable iff (!rstN)
    busClear |=> (!listenActive && !talkActive));

  p_clear_keeps_cfg_r11: assert property (@(posedge clk) disable iff (!rstN)
    busClear |=> ($stable(funcCode) && $stable(timeBase) && $stable(modeBits)
                  && $stable(levelA) && $stable(levelB) && $stable(displayBlank)));

  p_deaf_keeps_cfg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdModeN && !listenActive) |=> ($stable(funcCode) && $stable(timeBase)
      && $stable(modeBits) && $stable(levelA) && $stable(levelB) && $stable(displayBlank)));

  p_listen_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !cmdModeN && !busClear && devAddr != 5'h1F
     && byteIn[6:0] == {2'b01, devAddr}) |=> listenActive);

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(levelA) <= LVL_MAX && $signed(levelA) >= -LVL_MAX
     && $signed(levelB) <= LVL_MAX && $signed(levelB) >= -LVL_MAX));
endmodule

bind prog_listener prog_listener_chk #(.LVL_W(LVL_W), .LVL_MAX(LVL_MAX)) u_chk (.*);

// File: tb/prog_listener_tb.sv
module prog_listener_tb;
  localparam int LVL_W = 10;
  localparam int DEF_FUNC = 4;
  localparam logic [4:0] ADDR = 5'd9;

  logic clk = 1'b0, rstN = 1'b0, busClear = 1'b0, cmdModeN = 1'b1, byteValid = 1'b0;
  logic [7:0] byteIn = '0;
  logic listenActive, talkActive, displayBlank, resetPulse, trigPulse;
  logic [3:0] funcCode;
  logic [2:0] timeBase;
  logic [7:0] modeBits;
  logic [LVL_W-1:0] levelA, levelB;

  always #5 clk = ~clk;

  prog_listener u_dut (
    .clk(clk), .rstN(rstN), .busClear(busClear), .cmdModeN(cmdModeN),
    .byteValid(byteValid), .byteIn(byteIn), .devAddr(ADDR),
    .listenActive(listenActive), .talkActive(talkActive), .funcCode(funcCode),
    .timeBase(timeBase), .modeBits(modeBits), .displayBlank(displayBlank),
    .levelA(levelA), .levelB(levelB), .resetPulse(resetPulse), .trigPulse(trigPulse)
  );

  typedef struct {
    string tag;
    int listen, talk, func, tb, mode, blank, levA, levB, rst, trg;
  } expItem_t;

  expItem_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  // reference state built from the requirements
  int mListen, mTalk, mFunc, mTb, mMode, mBlank, mLevA, mLevB, eRst, eTrg;
  int mSt, mCh, mNeg, mAcc, mCnt;

  task automatic mDefaults();
    mFunc = DEF_FUNC; mTb = 0; mMode = 0; mBlank = 0; mLevA = 0; mLevB = 0; mSt = 0;
  endtask

  task automatic push(string tag);
    expItem_t it;
    it.tag = tag; it.listen = mListen; it.talk = mTalk; it.func = mFunc; it.tb = mTb;
    it.mode = mMode; it.blank = mBlank; it.levA = mLevA; it.levB = mLevB;
    it.rst = eRst; it.trg = eTrg;
    q.push_back(it);
  endtask

  task automatic mDispatch(int c);
    mSt = 0;
    case (c)
      'h46: mSt = 1;
      'h47: mSt = 2;
      'h53: mSt = 3;
      'h41: begin mCh = 0; mSt = 4; end
      'h42: begin mCh = 1; mSt = 4; end
      'h50: mDefaults();
      'h51: mBlank = 1;
      'h55: mBlank = 0;
      'h52: eRst = 1;
      'h54: begin eRst = 1; eTrg = 1; end
      default: ;
    endcase
  endtask

  task automatic mProg(int c);
    int v;
    case (mSt)
      0: mDispatch(c);
      1: begin if (c >= 'h30 && c <= 'h3F) mFunc = c - 'h30; mSt = 0; end
      2: begin if (c >= 'h30 && c <= 'h37) mTb = c - 'h30; mSt = 0; end
      3: begin
        if (c >= 'h30 && c <= 'h3F) begin
          v = c - 'h30;
          if (v % 2 == 1) mMode = mMode | (1 << (v / 2));
          else mMode = mMode & ~(1 << (v / 2));
        end else mDispatch(c);
      end
      4: begin
        if (c == 'h2B || c == 'h2D) begin mNeg = (c == 'h2D); mAcc = 0; mCnt = 0; mSt = 5; end
        else mSt = 0;
      end
      5: begin
        if (c >= 'h30 && c <= 'h39) begin
          mAcc = mAcc * 10 + c - 'h30; mCnt++;
          mSt = (mCnt == 3) ? 6 : 5;
        end else mSt = 0;
      end
      default: begin
        if (c == 'h2A && mAcc <= 250) begin
          if (mCh == 0) mLevA = mNeg ? -mAcc : mAcc;
          else mLevB = mNeg ? -mAcc : mAcc;
        end
        mSt = 0;
      end
    endcase
  endtask

  task automatic drive(logic [7:0] b, bit isCmd, string tag);
    int c;
    @(negedge clk);
    byteIn = b; cmdModeN = !isCmd; byteValid = 1'b1;
    @(posedge clk);
    #1 byteValid = 1'b0; cmdModeN = 1'b1;
    c = int'(b[6:0]);
    eRst = 0; eTrg = 0;
    if (isCmd) begin
      if (c == 'h14 || (c == 'h04 && mListen == 1)) mDefaults();
      if (c == 'h3F) mListen = 0;
      else if (c / 32 == 1 && c % 32 == int'(ADDR)) mListen = 1;
      if (c == 'h5F) mTalk = 0;
      else if (c / 32 == 2) mTalk = (c % 32 == int'(ADDR)) ? 1 : 0;
    end else if (mListen == 1) mProg(c);
    push(tag);
  endtask

  task automatic cmd(logic [7:0] b, string tag);
    drive(b, 1'b1, tag);
  endtask

  task automatic prog(string s, string tag);
    for (int i = 0; i < s.len(); i++) drive(8'(s[i]), 1'b0, tag);
  endtask

  task automatic clearBus(string tag);
    @(negedge clk);
    busClear = 1'b1;
    @(posedge clk);
    #1 busClear = 1'b0;
    mListen = 0; mTalk = 0; mSt = 0; eRst = 0; eTrg = 0;
    push(tag);
  endtask

  // monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      checks++;
      if (int'(listenActive) != e.listen || int'(talkActive) != e.talk ||
          int'(funcCode) != e.func || int'(timeBase) != e.tb ||
          int'(modeBits) != e.mode || int'(displayBlank) != e.blank ||
          int'($signed(levelA)) != e.levA || int'($signed(levelB)) != e.levB ||
          int'(resetPulse) != e.rst || int'(trigPulse) != e.trg) begin
        errors++;
        $display("FAIL %s: got L=%0d T=%0d f=%0d tb=%0d m=%h bl=%0d A=%0d B=%0d r=%0d t=%0d exp L=%0d T=%0d f=%0d tb=%0d m=%h bl=%0d A=%0d B=%0d r=%0d t=%0d",
          e.tag, listenActive, talkActive, funcCode, timeBase, modeBits, displayBlank,
          $signed(levelA), $signed(levelB), resetPulse, trigPulse,
          e.listen, e.talk, e.func, e.tb, e.mode, e.blank, e.levA, e.levB, e.rst, e.trg);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    mListen = 0; mTalk = 0; eRst = 0; eTrg = 0; mCh = 0; mNeg = 0; mAcc = 0; mCnt = 0;
    mDefaults();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    push("R1 reset state");
    prog("F7", "R4 program ignored while not listening");
    cmd(8'h46, "R4 letter under command phase is a talk address of another device");
    cmd(8'h2A, "R2 other listen address ignored");
    cmd(8'h29, "R2 own listen address");
    cmd(8'h2A, "R2 other listen address keeps listen");
    prog("F8", "R5 function load");
    prog("F?", "R5 function top code");
    prog("FZ3", "R5 invalid after F discarded");
    prog("G5", "R5 time base load");
    prog("G9", "R5 invalid time base discarded");
    prog("S1;?", "R6 mode bits set");
    prog("S0", "R6 mode bit clear");
    prog("S3Q", "R6 group ends on letter");
    prog("U", "R7 unblank");
    prog("R", "R7 reset strobe");
    push("R7 reset strobe drops");
    prog("T", "R7 reset and trigger strobes");
    prog("R", "R7 back to back strobe");
    push("R7 strobes drop");
    prog("A+123*", "R9 level A positive");
    prog("B-250*", "R9 level B at negative limit");
    prog("A+250*", "R9 level A at positive limit");
    prog("A+251*", "R10 level above limit discarded");
    prog("A-12*", "R10 short sequence discarded");
    prog("F2", "R10 parser idle after malformed");
    prog("AX", "R10 missing sign discarded");
    prog("B-000*", "R9 negative zero");
    cmd(8'h49, "R3 own talk address");
    cmd(8'h4A, "R3 other talk address clears talk");
    cmd(8'h49, "R3 own talk address again");
    cmd(8'h5F, "R3 untalk");
    cmd(8'hC9, "R3 bit 7 ignored");
    prog("A+1", "R11 partial level before clear");
    clearBus("R11 clear drops addressing keeps config");
    cmd(8'h29, "R2 listen again after clear");
    prog("2*", "R11 stale sequence not resumed");
    prog("G3S5", "R8 setup before selected clear");
    cmd(8'h04, "R8 selected device clear while listening");
    prog("F1G2S7", "R8 setup before device clear");
    cmd(8'h3F, "R2 unlisten");
    cmd(8'h04, "R8 selected clear ignored when not listening");
    cmd(8'h14, "R8 device clear for any device");
    cmd(8'h29, "R2 listen for P test");
    prog("F6QA+100*", "R8 setup before P");
    prog("P", "R8 program initialize");
    prog("3", "R8 parser idle after P");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule